// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block turns four operating-mode bits, written by software into the processor status word, into registered enables. The enables gate the main clock, the sub-main clock and the auxiliary clock. They also switch the oscillator DC generator and the crystal oscillator on and off, and they drive a CPU-halt line. The bit settings give one active mode and five low-power modes:

| Mode | cpu_off | osc_off | scg0 | scg1 |
|------|---------|---------|------|------|
| Active | 0 | 0 | 0 | 0 |
| LPM0 | 1 | 0 | 0 | 0 |
| LPM1 | 1 | 0 | 1 | 0 |
| LPM2 | 1 | 0 | 0 | 1 |
| LPM3 | 1 | 0 | 1 | 1 |
| LPM4 | 1 | 1 | 1 | 1 |

An input flag tells the block whether the oscillator serves as the clock source in active mode. In LPM1 the DC generator may be switched off only when that flag is clear.

An accepted interrupt moves the block to active mode, so that the service routine runs with every clock on. At that moment the mode in force is copied into a one-entry shadow register. The return-from-interrupt strobe restores that saved mode. All enables are flops updated from the next-state decode, so a gate only changes at a clock edge. Reset is asserted asynchronously and released through a synchronizer.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While reset is held and just after it is released, the main, sub-main and auxiliary clock enables are 1, the DC generator and crystal enables are 1, and cpu_halt_o is 0. This holds whatever the mode inputs are.
- R2: With all four mode bits 0 and no service in progress, every enable is 1 and cpu_halt_o is 0.
- R3: cpu_off_i=1 sets cpu_halt_o to 1 and mclk_en_o to 0. The sub-main and auxiliary enables stay 1 unless their own bits are set (LPM0 = 1000 in the order cpu_off, osc_off, scg0, scg1).
- R4: scg1_i=1 sets smclk_en_o to 0 (LPM2, LPM3 and LPM4).
- R5: osc_off_i=1 sets both aclk_en_o and xtal_en_o to 0 (LPM4 = 1111).
- R6: dcgen_en_o is 0 exactly when scg0_i is 1 and either scg1_i is 1 or dco_act_i is 0. So LPM1 keeps the generator on only when dco_act_i=1, LPM2 keeps it on, and LPM3 and LPM4 turn it off.
- R7: Outputs follow the mode inputs one clock edge later, and they do not change between edges.
- R8: An irq_i pulse with no service in progress gives active-mode outputs at the next edge. The same edge saves the mode then in force.
- R9: While a service is in progress, changes on the mode inputs and further irq_i pulses are ignored, and the outputs stay in active mode.
- R10: reti_i during a service, without irq_i, restores the saved mode at the next edge even if the mode inputs differ. From the edge after that, the outputs follow the mode inputs again.
- R11: reti_i with no service in progress has no effect, and the outputs keep following the mode inputs.
- R12: irq_i and reti_i in the same cycle during a service keep the block in active mode with the saved mode unchanged. A later lone reti_i restores the original mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_off_i | input | 1 | Status bit: halt CPU, gate main clock |
| osc_off_i | input | 1 | Status bit: stop crystal, gate auxiliary clock |
| scg0_i | input | 1 | Status bit: DC generator off request |
| scg1_i | input | 1 | Status bit: gate sub-main clock |
| dco_act_i | input | 1 | Oscillator is the active-mode clock source |
| irq_i | input | 1 | Interrupt-accepted strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| mclk_en_o | output | 1 | Main clock enable |
| smclk_en_o | output | 1 | Sub-main clock enable |
| aclk_en_o | output | 1 | Auxiliary clock enable |
| dcgen_en_o | output | 1 | Oscillator DC generator enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| cpu_halt_o | output | 1 | CPU halt |

## Verification
The interrupt strobe and the return strobe can arrive in the same cycle while a service is in progress. The bench provokes this after entering LPM2 and then setting the mode inputs to active, so that the saved mode and the live inputs disagree. It judges the collision correct if the outputs stay in active mode, and if a later lone return brings back LPM2 rather than the live inputs.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef struct packed {
    logic cpu_off;
    logic osc_off;
    logic scg0;
    logic scg1;
  } lpm_mode_t;

  localparam int MODE_W = $bits(lpm_mode_t);
  localparam lpm_mode_t MODE_ACTIVE = '0;

  typedef struct packed {
    logic mclk;
    logic smclk;
    logic aclk;
    logic dcgen;
    logic xtal;
    logic halt;
  } lpm_en_t;

  localparam int EN_W = $bits(lpm_en_t);
  localparam logic [EN_W-1:0] EN_RESET = {{(EN_W-1){1'b1}}, 1'b0};

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lpm_mode_t req_mode,
  input  logic      irq_i,
  input  logic      reti_i,
  output lpm_mode_t mode_nxt,
  output logic      svc_q,
  output lpm_mode_t shadow_q
);
  lpm_mode_t mode_q, shadow_d;
  logic      svc_d, accept, ret, chain;

  assign accept = irq_i & ~svc_q;
  assign ret    = reti_i & svc_q;
  assign chain  = ret & irq_i;

  always_comb begin
    mode_nxt = req_mode;
    shadow_d = shadow_q;
    svc_d    = svc_q;
    if (chain) begin
      mode_nxt = MODE_ACTIVE;
      svc_d    = 1'b1;
    end else if (ret) begin
      mode_nxt = shadow_q;
      svc_d    = 1'b0;
    end else if (accept) begin
      shadow_d = mode_q;
      mode_nxt = MODE_ACTIVE;
      svc_d    = 1'b1;
    end else if (svc_q) begin
      mode_nxt = MODE_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_ACTIVE;
      shadow_q <= MODE_ACTIVE;
      svc_q    <= 1'b0;
    end else begin
      mode_q <= mode_nxt;
      svc_q  <= svc_d;
      if (accept) shadow_q <= shadow_d;
    end
  end
endmodule

// File: rtl/lpm_clk_decode.sv
module lpm_clk_decode
  import lpm_pkg::*;
(
  input  lpm_mode_t mode,
  input  logic      dco_act,
  output lpm_en_t   en
);
  always_comb begin
    en.halt  = mode.cpu_off;
    en.mclk  = ~mode.cpu_off;
    en.smclk = ~mode.scg1;
    en.aclk  = ~mode.osc_off;
    en.xtal  = ~mode.osc_off;
    en.dcgen = ~mode.scg0 | (dco_act & ~mode.scg1);
  end
endmodule

// File: rtl/lpm_en_reg.sv
module lpm_en_reg #(
  parameter int           W       = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic upd;
    assign upd = d[g] ^ q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[g] <= RST_VAL[g];
      else if (upd) q[g] <= d[g];
    end
  end
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_off_i,
  input  logic osc_off_i,
  input  logic scg0_i,
  input  logic scg1_i,
  input  logic dco_act_i,
  input  logic irq_i,
  input  logic reti_i,
  output logic mclk_en_o,
  output logic smclk_en_o,
  output logic aclk_en_o,
  output logic dcgen_en_o,
  output logic xtal_en_o,
  output logic cpu_halt_o
);
  logic      rst_sync_n;
  logic      svc_q;
  lpm_mode_t req_mode, mode_nxt, shadow_q;
  lpm_en_t   en_nxt, en_q;

  lpm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign req_mode.cpu_off = cpu_off_i;
  assign req_mode.osc_off = osc_off_i;
  assign req_mode.scg0    = scg0_i;
  assign req_mode.scg1    = scg1_i;

  lpm_wake_ctrl u_wake (
    .clk(clk), .rst_n(rst_sync_n), .req_mode(req_mode),
    .irq_i(irq_i), .reti_i(reti_i),
    .mode_nxt(mode_nxt), .svc_q(svc_q), .shadow_q(shadow_q)
  );

  lpm_clk_decode u_dec (
    .mode(mode_nxt), .dco_act(dco_act_i), .en(en_nxt)
  );

  lpm_en_reg #(.W(EN_W), .RST_VAL(EN_RESET)) u_reg (
    .clk(clk), .rst_n(rst_sync_n), .d(en_nxt), .q(en_q)
  );

  assign mclk_en_o  = en_q.mclk;
  assign smclk_en_o = en_q.smclk;
  assign aclk_en_o  = en_q.aclk;
  assign dcgen_en_o = en_q.dcgen;
  assign xtal_en_o  = en_q.xtal;
  assign cpu_halt_o = en_q.halt;
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_off_i,
  input logic       osc_off_i,
  input logic       scg0_i,
  input logic       scg1_i,
  input logic       irq_i,
  input logic       reti_i,
  input logic       svc_q,
  input logic [3:0] shadow,
  input logic       mclk_en_o,
  input logic       smclk_en_o,
  input logic       aclk_en_o,
  input logic       dcgen_en_o,
  input logic       xtal_en_o,
  input logic       cpu_halt_o
);
  // R8
  irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && !svc_q) |=> (svc_q && !cpu_halt_o && mclk_en_o && smclk_en_o
                           && aclk_en_o && xtal_en_o && dcgen_en_o));
  // R8
  irq_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_i && !svc_q) |=> (shadow[3] == $past(cpu_halt_o)
                           && shadow[0] == !$past(smclk_en_o)
                           && shadow[2] == !$past(aclk_en_o)));
  // R9
  svc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q && !reti_i) |=> (svc_q && $stable(shadow) && mclk_en_o && !cpu_halt_o));
  // R10
  ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q && reti_i && !irq_i) |=> (!svc_q && cpu_halt_o == $past(shadow[3])
                                     && smclk_en_o == !$past(shadow[0])
                                     && aclk_en_o == !$past(shadow[2])));
  // R12
  chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_q && reti_i && irq_i) |=> (svc_q && $stable(shadow) && !cpu_halt_o));
  // R3
  track_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_q && !irq_i) |=> (cpu_halt_o == $past(cpu_off_i) && mclk_en_o == !$past(cpu_off_i)));
  // R4
  track_scg1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_q && !irq_i) |=> (smclk_en_o == !$past(scg1_i)));
  // R5
  osc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_q && !irq_i && osc_off_i) |=> (!aclk_en_o && !xtal_en_o));
  // R6
  dcgen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!svc_q && !irq_i && scg0_i && scg1_i) |=> !dcgen_en_o);
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .cpu_off_i(cpu_off_i), .osc_off_i(osc_off_i), .scg0_i(scg0_i), .scg1_i(scg1_i),
  .irq_i(irq_i), .reti_i(reti_i), .svc_q(svc_q), .shadow(shadow_q),
  .mclk_en_o(mclk_en_o), .smclk_en_o(smclk_en_o), .aclk_en_o(aclk_en_o),
  .dcgen_en_o(dcgen_en_o), .xtal_en_o(xtal_en_o), .cpu_halt_o(cpu_halt_o)
);

// File: tb/sim_lpm_clk_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_clk_ctrl;
  logic clk = 1'b0;
  logic rst_n, cpu_off, osc_off, scg0, scg1, dco_act, irq, reti;
  logic mclk_en, smclk_en, aclk_en, dcgen_en, xtal_en, halt;
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  lpm_clk_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cpu_off_i(cpu_off), .osc_off_i(osc_off),
    .scg0_i(scg0), .scg1_i(scg1), .dco_act_i(dco_act), .irq_i(irq), .reti_i(reti),
    .mclk_en_o(mclk_en), .smclk_en_o(smclk_en), .aclk_en_o(aclk_en),
    .dcgen_en_o(dcgen_en), .xtal_en_o(xtal_en), .cpu_halt_o(halt)
  );

  // order: mclk smclk aclk dcgen xtal halt
  function automatic logic [5:0] exp_of(logic c, logic o, logic s0, logic s1, logic d);
    return {~c, ~s1, ~o, ~s0 | (d & ~s1), ~o, c};
  endfunction

  localparam logic [5:0] ACT = 6'b111110;

  task automatic check(string req, logic [5:0] exp);
    logic [5:0] got;
    got = {mclk_en, smclk_en, aclk_en, dcgen_en, xtal_en, halt};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic set_mode(logic c, logic o, logic s0, logic s1, logic d);
    cpu_off = c; osc_off = o; scg0 = s0; scg1 = s1; dco_act = d;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq = 1'b0; reti = 1'b0;
    set_mode(1, 1, 1, 1, 0);
    tick(); tick();
    check("R1 during reset", ACT);
    set_mode(0, 0, 0, 0, 0);
    tick();
    rst_n = 1'b1;
    tick(); tick(); tick();
    check("R1 after release", ACT);

    // R7: no change before the edge, new value after it
    set_mode(1, 1, 1, 1, 0);
    #2 check("R7 before edge", ACT);
    tick();
    check("R5 LPM4", exp_of(1, 1, 1, 1, 0));

    // exhaustive sweep of mode bits and oscillator flag
    for (int i = 0; i < 32; i++) begin
      set_mode(i[4], i[3], i[2], i[1], i[0]);
      tick();
      check("R6 sweep", exp_of(i[4], i[3], i[2], i[1], i[0]));
    end

    set_mode(0, 0, 0, 0, 1); tick(); check("R2 active", ACT);
    set_mode(1, 0, 0, 0, 1); tick(); check("R3 LPM0", 6'b011111);
    set_mode(1, 0, 0, 1, 1); tick(); check("R4 LPM2", 6'b001111);
    set_mode(1, 0, 1, 0, 1); tick(); check("R6 LPM1 osc used", 6'b011111);
    set_mode(1, 0, 1, 0, 0); tick(); check("R6 LPM1 osc unused", 6'b011011);
    set_mode(1, 0, 1, 1, 1); tick(); check("R6 LPM3", 6'b001011);

    // wake from LPM3, ignore inputs during service, restore
    irq = 1'b1; tick(); irq = 1'b0;
    check("R8 wake", ACT);
    set_mode(1, 1, 1, 1, 1); irq = 1'b1; tick(); irq = 1'b0;
    check("R9 ignore inputs and irq", ACT);
    tick(); check("R9 still active", ACT);
    set_mode(0, 0, 0, 0, 1); reti = 1'b1; tick(); reti = 1'b0;
    check("R10 restore LPM3", 6'b001011);
    tick(); check("R10 track after restore", ACT);

    // return without service
    set_mode(1, 0, 0, 0, 1); reti = 1'b1; tick(); reti = 1'b0;
    check("R11 stray return", 6'b011111);

    // collision of irq and reti in service
    set_mode(1, 0, 0, 1, 0); tick(); check("R4 LPM2 entry", 6'b001111);
    irq = 1'b1; tick(); irq = 1'b0; check("R8 wake from LPM2", ACT);
    set_mode(0, 0, 0, 0, 0);
    irq = 1'b1; reti = 1'b1; tick(); irq = 1'b0; reti = 1'b0;
    check("R12 collision stays active", ACT);
    tick(); check("R12 still in service", ACT);
    reti = 1'b1; tick(); reti = 1'b0;
    check("R12 saved mode kept", 6'b001111);
    tick(); check("R10 track", ACT);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule